// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is an I2C target that presents itself to a bus controller as a small serial EEPROM holding sixteen bytes. The SCL and SDA lines are brought into the system clock domain through a synchronizer. Start conditions, stop conditions and SCL edges are found from the synchronized samples, and a state machine decodes the frames. The block drives SDA only through an open-drain pull-low output: `sda_pull_o` high means the line is held low.

A frame opens with a control byte. Its upper nibble must equal the EEPROM device type `1010` and its next three bits must equal the chip-select strap pins. The last bit picks the operation. A write frame carries an address byte and then one data byte, which is stored at that address unless the write-protect pin is high. A read frame returns the byte at the internal address pointer and keeps sending further bytes for as long as the controller acknowledges them. The pointer advances after every data byte, in either direction, and wraps from the last location back to zero. A write frame that is cut short by a repeated start after its address byte acts as a pointer load, which gives a random read.

The state machine uses these states:
- IDLE: no frame is open.
- CTRL, ADDR, DATA: shifting in a control, address or data byte.
- CTRL_ACK, ADDR_ACK, DATA_ACK: holding the acknowledge low during the ninth clock.
- READ: shifting a byte out.
- READ_ACK: sampling the controller's answer.
- READ_GAP: waiting for the end of an acknowledged ninth clock.
- HOLD: silent until the next start or stop.

The state machine takes these transitions:
- Start from any state goes to CTRL.
- Stop from any state goes to IDLE.
- CTRL goes to CTRL_ACK when the control byte matches, and to HOLD when it does not.
- CTRL_ACK goes to ADDR for a write and to READ for a read.
- ADDR goes to ADDR_ACK.
- ADDR_ACK goes to DATA.
- DATA goes to DATA_ACK.
- DATA_ACK goes to HOLD.
- READ goes to READ_ACK.
- READ_ACK goes to READ_GAP on an acknowledge and to HOLD on a not-acknowledge.
- READ_GAP goes to READ.

Top module: `eeprom_i2c_target`

## Requirements
- R1: A control byte is acknowledged only when its bits 7..4 are `1010` and its bits 3..1 equal `cs_strap_i[2:0]`. Otherwise SDA stays released for the rest of that frame.
- R2: Bit 0 of a matching control byte selects the operation: 0 starts a write frame (an address byte follows) and 1 starts a read frame (the target sends data).
- R3: In a write frame the target pulls SDA low during the ninth clock of the control, address and data bytes. When write protect is low, the data byte is stored at the addressed location. Any further byte in the same frame is not acknowledged and changes nothing.
- R4: In a read frame the target sends the byte at the address pointer, most significant bit first, over eight clocks. It changes SDA only while SCL is low and releases SDA for the ninth clock.
- R5: When the controller acknowledges (SDA low on the ninth clock), the next location's byte follows. On a not-acknowledge the target keeps SDA released until a stop or start.
- R6: While `wp_i` is high, no data byte changes storage, and the data byte is still acknowledged.
- R7: Only bits 3..0 of the address byte load the pointer. The pointer advances by one after every data byte written (protected or not) or sent, and moves from 15 to 0.
- R8: A start condition at any point abandons the current frame and begins control-byte matching. A stop returns the target to idle. Bits clocked outside a frame are ignored.
- R9: After reset every stored byte is 0x00, the pointer is 0 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_pull_o | output | 1 | High pulls SDA low; low leaves the line released |
| cs_strap_i | input | 3 | Chip-select straps compared with control bits 3..1 |
| wp_i | input | 1 | Write protect; high blocks all storage changes |

## Verification
The embedded assertions cover several behaviours on every clock cycle:
- SDA is never pulled after a control byte that does not match.
- The pull output never moves in the cycle after an SCL rise.
- A not-acknowledge always leads to the silent state.
- Start and stop always redirect the state machine.
- Storage is frozen under write protect, and an unprotected write lands at the pointer.
- The pointer wraps from 15 to 0.

Only the bench's bus scenarios can show the following:
- The byte values returned with their bit order.
- The combined effect of pointer loads, protected writes and sequential reads across several frames.
- That bytes after the data byte, or bytes clocked outside a frame, leave storage untouched.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;

    localparam int          BYTE_BITS = 8;
    localparam int          CS_BITS   = 3;
    localparam logic [3:0]  DEV_TYPE  = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_READ,
        ST_READ_ACK,
        ST_READ_GAP,
        ST_HOLD
    } frame_state_e;

endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    // index 0 carries SCL, index 1 carries SDA
    logic [1:0] raw;
    logic [1:0] lvl;
    logic [1:0] lvl_d;

    assign raw = {sda_raw, scl_raw};

    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [STAGES-1:0] pipe;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe <= '1;
            end else begin
                pipe <= {pipe[STAGES-2:0], raw[g]};
            end
        end
        assign lvl[g] = pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_d <= '1;
        end else begin
            lvl_d <= lvl;
        end
    end

    assign sda_lvl   = lvl[1];
    assign scl_rise  = lvl[0] & ~lvl_d[0];
    assign scl_fall  = ~lvl[0] & lvl_d[0];
    assign start_det = lvl[0] & lvl_d[0] & lvl_d[1] & ~lvl[1];
    assign stop_det  = lvl[0] & lvl_d[0] & ~lvl_d[1] & lvl[1];

endmodule

// File: rtl/byte_store.sv
module byte_store #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wp_i,
    input  logic          ptr_load,
    input  logic [AW-1:0] ptr_val,
    input  logic          ptr_adv,
    input  logic          wr_req,
    input  logic [7:0]    wr_data,
    output logic [7:0]    rd_data
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DEPTH-1:0][7:0] mem_q;
    logic [AW-1:0]         ptr_q;
    logic [AW-1:0]         ptr_inc;

    assign ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    assign rd_data = mem_q[ptr_q];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (ptr_load) begin
            ptr_q <= ptr_val;
        end else if (wr_req || ptr_adv) begin
            ptr_q <= ptr_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else if (wr_req && !wp_i) begin
            mem_q[ptr_q] <= wr_data;
        end
    end

    assert_wp_freezes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_i && wr_req) |=> $stable(mem_q));

    assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wp_i) |=> (mem_q[$past(ptr_q)] == $past(wr_data)));

    assert_ptr_wraps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_req || ptr_adv) && !ptr_load && ptr_q == LAST) |=> (ptr_q == '0));

endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
    import eeprom_i2c_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic               sda_lvl,
    input  logic [CS_BITS-1:0] cs_strap,
    input  logic [7:0]         rd_data,
    output logic               ptr_load,
    output logic [AW-1:0]      ptr_val,
    output logic               ptr_adv,
    output logic               wr_req,
    output logic [7:0]         wr_data,
    output logic               sda_pull
);

    localparam int             CW       = $clog2(BYTE_BITS + 1);
    localparam logic [CW-1:0]  CNT_FULL = CW'(BYTE_BITS);
    localparam logic [CW-1:0]  CNT_LAST = CW'(BYTE_BITS - 1);

    frame_state_e           state_q, state_nx;
    logic [CW-1:0]          cnt_q, cnt_nx;
    logic [BYTE_BITS-1:0]   shreg_q, shreg_nx;
    logic                   rw_q, rw_nx;

    logic evt_ok;
    logic byte_end;
    logic rx_shift;
    logic addr_hit;
    logic [BYTE_BITS-1:0] shreg_in;

    assign evt_ok   = !start_det && !stop_det;
    assign byte_end = scl_fall && (cnt_q == CNT_FULL);
    assign rx_shift = scl_rise && (cnt_q != CNT_FULL);
    assign addr_hit = (shreg_q[BYTE_BITS-1:1] == {DEV_TYPE, cs_strap});
    assign shreg_in = {shreg_q[BYTE_BITS-2:0], sda_lvl};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            shreg_q <= '0;
            rw_q    <= 1'b0;
        end else begin
            state_q <= state_nx;
            cnt_q   <= cnt_nx;
            shreg_q <= shreg_nx;
            rw_q    <= rw_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state_q;
        cnt_nx   = cnt_q;
        shreg_nx = shreg_q;
        rw_nx    = rw_q;
        if (stop_det) begin
            state_nx = ST_IDLE;
        end else if (start_det) begin
            state_nx = ST_CTRL;
            cnt_nx   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_HOLD: begin
                end
                ST_CTRL: begin
                    if (rx_shift) begin
                        shreg_nx = shreg_in;
                        cnt_nx   = cnt_q + 1'b1;
                    end else if (byte_end) begin
                        if (addr_hit) begin
                            rw_nx    = shreg_q[0];
                            state_nx = ST_CTRL_ACK;
                        end else begin
                            state_nx = ST_HOLD;
                        end
                    end
                end
                ST_ADDR: begin
                    if (rx_shift) begin
                        shreg_nx = shreg_in;
                        cnt_nx   = cnt_q + 1'b1;
                    end else if (byte_end) begin
                        state_nx = ST_ADDR_ACK;
                    end
                end
                ST_DATA: begin
                    if (rx_shift) begin
                        shreg_nx = shreg_in;
                        cnt_nx   = cnt_q + 1'b1;
                    end else if (byte_end) begin
                        state_nx = ST_DATA_ACK;
                    end
                end
                ST_CTRL_ACK: begin
                    if (scl_fall) begin
                        cnt_nx = '0;
                        if (rw_q) begin
                            shreg_nx = rd_data;
                            state_nx = ST_READ;
                        end else begin
                            state_nx = ST_ADDR;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        cnt_nx   = '0;
                        state_nx = ST_DATA;
                    end
                end
                ST_DATA_ACK: begin
                    if (scl_fall) begin
                        state_nx = ST_HOLD;
                    end
                end
                ST_READ: begin
                    if (scl_fall) begin
                        if (cnt_q == CNT_LAST) begin
                            state_nx = ST_READ_ACK;
                        end else begin
                            shreg_nx = {shreg_q[BYTE_BITS-2:0], 1'b1};
                            cnt_nx   = cnt_q + 1'b1;
                        end
                    end
                end
                ST_READ_ACK: begin
                    if (scl_rise) begin
                        state_nx = sda_lvl ? ST_HOLD : ST_READ_GAP;
                    end
                end
                ST_READ_GAP: begin
                    if (scl_fall) begin
                        shreg_nx = rd_data;
                        cnt_nx   = '0;
                        state_nx = ST_READ;
                    end
                end
                default: begin
                    state_nx = ST_IDLE;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        ptr_load = evt_ok && (state_q == ST_ADDR) && byte_end;
        wr_req   = evt_ok && (state_q == ST_DATA) && byte_end;
        ptr_adv  = evt_ok && scl_fall &&
                   (((state_q == ST_CTRL_ACK) && rw_q) || (state_q == ST_READ_GAP));
        unique case (state_q)
            ST_CTRL_ACK, ST_ADDR_ACK, ST_DATA_ACK: sda_pull = 1'b1;
            ST_READ:                               sda_pull = !shreg_q[BYTE_BITS-1];
            default:                               sda_pull = 1'b0;
        endcase
    end

    assign ptr_val = shreg_q[AW-1:0];
    assign wr_data = shreg_q;

    assert_ctrl_mismatch_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CTRL && byte_end && evt_ok && !addr_hit) |=> !sda_pull);

    assert_pull_steady_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise |=> $stable(sda_pull));

    assert_nak_goes_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ_ACK && scl_rise && sda_lvl && evt_ok) |=> (state_q == ST_HOLD));

    assert_start_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state_q == ST_CTRL && cnt_q == '0));

    assert_stop_idles_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state_q == ST_IDLE));

endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target #(
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    input  logic [2:0] cs_strap_i,
    input  logic       wp_i
);

    localparam int AW = $clog2(DEPTH);

    logic          sda_lvl;
    logic          scl_rise;
    logic          scl_fall;
    logic          start_det;
    logic          stop_det;
    logic          ptr_load;
    logic [AW-1:0] ptr_val;
    logic          ptr_adv;
    logic          wr_req;
    logic [7:0]    wr_data;
    logic [7:0]    rd_data;

    line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_raw   (scl_i),
        .sda_raw   (sda_i),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    frame_ctrl #(
        .AW (AW)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_lvl   (sda_lvl),
        .cs_strap  (cs_strap_i),
        .rd_data   (rd_data),
        .ptr_load  (ptr_load),
        .ptr_val   (ptr_val),
        .ptr_adv   (ptr_adv),
        .wr_req    (wr_req),
        .wr_data   (wr_data),
        .sda_pull  (sda_pull_o)
    );

    byte_store #(
        .DEPTH (DEPTH),
        .AW    (AW)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wp_i     (wp_i),
        .ptr_load (ptr_load),
        .ptr_val  (ptr_val),
        .ptr_adv  (ptr_adv),
        .wr_req   (wr_req),
        .wr_data  (wr_data),
        .rd_data  (rd_data)
    );

endmodule

// File: tb/sim_eeprom_i2c_target.sv
module sim_eeprom_i2c_target;

    localparam int H = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       wp_b = 1'b0;
    logic [2:0] strap = 3'd5;
    logic       sda_pull;
    logic       sda_line;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    assign sda_line = sda_m & ~sda_pull;

    always #4 clk = ~clk;

    eeprom_i2c_target u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull),
        .cs_strap_i (strap),
        .wp_i       (wp_b)
    );

    // kind: 0 write byte, 1 read at pointer, 2 load pointer then read
    typedef struct packed {
        logic [1:0] kind;
        logic       wp;
        logic [2:0] cs;
        logic [7:0] addr;
        logic [7:0] data;
        logic       ack;
        logic [7:0] exp;
    } vec_t;

    localparam vec_t VECS [11] = '{
        '{2'd0, 1'b0, 3'd5, 8'h03, 8'hA6, 1'b1, 8'h00},
        '{2'd0, 1'b0, 3'd5, 8'h1F, 8'h3D, 1'b1, 8'h00},
        '{2'd0, 1'b0, 3'd5, 8'h10, 8'h5A, 1'b1, 8'h00},
        '{2'd0, 1'b1, 3'd5, 8'h03, 8'hFF, 1'b1, 8'h00},
        '{2'd0, 1'b0, 3'd2, 8'h03, 8'h11, 1'b0, 8'h00},
        '{2'd1, 1'b0, 3'd5, 8'h00, 8'h00, 1'b1, 8'h00},
        '{2'd2, 1'b0, 3'd5, 8'h03, 8'h00, 1'b1, 8'hA6},
        '{2'd2, 1'b0, 3'd5, 8'h0F, 8'h00, 1'b1, 8'h3D},
        '{2'd1, 1'b0, 3'd5, 8'h00, 8'h00, 1'b1, 8'h5A},
        '{2'd1, 1'b0, 3'd6, 8'h00, 8'h00, 1'b0, 8'hFF},
        '{2'd2, 1'b0, 3'd5, 8'h43, 8'h00, 1'b1, 8'hA6}
    };

    function automatic string tag_of(vec_t v);
        if (!v.ack)                  return "R1";
        if (v.wp)                    return "R6";
        if (v.addr[7:4] != 4'h0)     return "R7";
        if (v.kind == 2'd0)          return "R3";
        if (v.kind == 2'd1)          return "R2";
        return "R4";
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1;
        wait_clk(H);
        scl_m = 1'b1;
        wait_clk(H);
        sda_m = 1'b0;
        wait_clk(H);
        scl_m = 1'b0;
        wait_clk(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0;
        wait_clk(H);
        scl_m = 1'b1;
        wait_clk(H);
        sda_m = 1'b1;
        wait_clk(H);
    endtask

    task automatic clock_bit(input logic b);
        sda_m = b;
        wait_clk(H);
        scl_m = 1'b1;
        wait_clk(H);
        scl_m = 1'b0;
        wait_clk(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            clock_bit(b[i]);
        end
        sda_m = 1'b1;
        wait_clk(H);
        scl_m = 1'b1;
        wait_clk(H / 2);
        ack = !sda_line;
        wait_clk(H / 2);
        scl_m = 1'b0;
        wait_clk(2);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_clk(H);
            scl_m = 1'b1;
            wait_clk(H / 2);
            b[i] = sda_line;
            wait_clk(H / 2);
            scl_m = 1'b0;
            wait_clk(2);
        end
        sda_m = !give_ack;
        wait_clk(H);
        scl_m = 1'b1;
        wait_clk(H);
        scl_m = 1'b0;
        wait_clk(2);
        sda_m = 1'b1;
    endtask

    task automatic do_write(input logic [2:0] cs, input logic [7:0] a, input logic [7:0] d,
                            output logic [2:0] acks);
        bus_start();
        send_byte({4'b1010, cs, 1'b0}, acks[2]);
        send_byte(a, acks[1]);
        send_byte(d, acks[0]);
        bus_stop();
    endtask

    task automatic do_point(input logic [2:0] cs, input logic [7:0] a, output logic [1:0] acks);
        bus_start();
        send_byte({4'b1010, cs, 1'b0}, acks[1]);
        send_byte(a, acks[0]);
    endtask

    task automatic do_read(input logic [2:0] cs, output logic ack, output logic [7:0] d);
        bus_start();
        send_byte({4'b1010, cs, 1'b1}, ack);
        recv_byte(1'b0, d);
        bus_stop();
    endtask

    initial begin
        logic       ack;
        logic [1:0] a2;
        logic [2:0] a3;
        logic [7:0] d;

        // R9: reset state
        wait_clk(10);
        chk("R9", {7'b0, sda_pull}, 8'h00);
        rst_n = 1'b1;
        wait_clk(5);
        chk("R9", {7'b0, sda_pull}, 8'h00);
        do_read(3'd5, ack, d);
        chk("R9", {7'b0, ack}, 8'h01);
        chk("R9", d, 8'h00);

        // vector table
        for (int k = 0; k < 11; k++) begin
            vec_t v;
            v = VECS[k];
            wp_b = v.wp;
            unique case (v.kind)
                2'd0: begin
                    do_write(v.cs, v.addr, v.data, a3);
                    chk(tag_of(v), {7'b0, a3[2]}, {7'b0, v.ack});
                    chk(tag_of(v), {7'b0, a3[1]}, {7'b0, v.ack});
                    chk(tag_of(v), {7'b0, a3[0]}, {7'b0, v.ack});
                end
                2'd1: begin
                    do_read(v.cs, ack, d);
                    chk(tag_of(v), {7'b0, ack}, {7'b0, v.ack});
                    chk(tag_of(v), d, v.exp);
                end
                default: begin
                    do_point(v.cs, v.addr, a2);
                    chk(tag_of(v), {6'b0, a2}, {6'b0, v.ack, v.ack});
                    do_read(v.cs, ack, d);
                    chk(tag_of(v), {7'b0, ack}, {7'b0, v.ack});
                    chk(tag_of(v), d, v.exp);
                end
            endcase
            wp_b = 1'b0;
        end

        // R6: protected write leaves data, reads still work
        wp_b = 1'b1;
        do_write(3'd5, 8'h03, 8'h00, a3);
        chk("R6", {5'b0, a3}, 8'h07);
        do_point(3'd5, 8'h03, a2);
        do_read(3'd5, ack, d);
        chk("R6", d, 8'hA6);
        wp_b = 1'b0;

        // R3: byte after the data byte is not acknowledged and not stored
        bus_start();
        send_byte({4'b1010, 3'd5, 1'b0}, ack);
        send_byte(8'h05, ack);
        send_byte(8'h21, ack);
        chk("R3", {7'b0, ack}, 8'h01);
        send_byte(8'h99, ack);
        chk("R3", {7'b0, ack}, 8'h00);
        bus_stop();
        do_point(3'd5, 8'h05, a2);
        bus_start();
        send_byte({4'b1010, 3'd5, 1'b1}, ack);
        recv_byte(1'b1, d);
        chk("R3", d, 8'h21);
        recv_byte(1'b0, d);
        chk("R3", d, 8'h00);
        bus_stop();

        // R5 / R7: sequential read across the wrap, then silence after NAK
        do_write(3'd5, 8'h0E, 8'h77, a3);
        chk("R5", {5'b0, a3}, 8'h07);
        do_point(3'd5, 8'h0E, a2);
        bus_start();
        send_byte({4'b1010, 3'd5, 1'b1}, ack);
        recv_byte(1'b1, d);
        chk("R5", d, 8'h77);
        recv_byte(1'b1, d);
        chk("R5", d, 8'h3D);
        recv_byte(1'b0, d);
        chk("R7", d, 8'h5A);
        recv_byte(1'b0, d);
        chk("R5", d, 8'hFF);
        bus_stop();

        // R8: start in the middle of a control byte restarts matching
        do_point(3'd5, 8'h03, a2);
        bus_stop();
        bus_start();
        clock_bit(1'b1);
        clock_bit(1'b0);
        clock_bit(1'b1);
        clock_bit(1'b0);
        bus_start();
        send_byte({4'b1010, 3'd5, 1'b1}, ack);
        chk("R8", {7'b0, ack}, 8'h01);
        recv_byte(1'b0, d);
        chk("R8", d, 8'hA6);
        bus_stop();

        // R8: stop ends a frame; bits clocked outside a frame are ignored
        bus_start();
        send_byte({4'b1010, 3'd5, 1'b0}, ack);
        send_byte(8'h05, ack);
        bus_stop();
        scl_m = 1'b0;
        wait_clk(H);
        send_byte(8'h44, ack);
        chk("R8", {7'b0, ack}, 8'h00);
        bus_stop();
        do_point(3'd5, 8'h05, a2);
        do_read(3'd5, ack, d);
        chk("R8", d, 8'h21);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule